// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block resolves a translation miss by walking a three-level radix page-table tree held in memory. A miss request carries a 42-bit virtual address and a process ID. The walker splits the address into three 10-bit index fields above a 12-bit page offset. It then reads one 32-bit entry per level through a simple read request/response port. The root table is located by a page-table base input, given as a physical page number, and the walker samples that input when it accepts the request.

Each entry holds a present flag, three attribute flags and an 18-bit physical page number. A present entry at level one or two names the table for the next level. A present entry at level three names the target page. The first entry found not present ends the walk with a fault that reports its level. A successful walk returns the page number, the assembled 30-bit physical address and the attribute flags of the last-level entry. The surrounding translation cache feeds misses in and installs the results. It can use the fault report to raise an exception.

Top module: `pt_walker`

## Requirements
- R1: After reset, `reqReady` is 1 and `memReqValid` and `resValid` are 0.
- R2: The level-1, level-2 and level-3 indices are VA bits 41:32, 31:22 and 21:12, and the offset is VA bits 11:0. The root table page number is `ptBasePpn` sampled in the cycle the request is accepted; later changes to it have no effect on that walk.
- R3: Every read address is the current table page number shifted left by 12, plus four times the index for the current level, as a 30-bit byte address.
- R4: `memReqValid` is high for exactly one cycle per level. That cycle is the first cycle after the request is accepted, or the first cycle after the previous level's response. It stays low while a response is awaited.
- R5: A response may come any number of cycles after the request cycle. A `memRespValid` in the request cycle itself, or while no read is outstanding, is ignored.
- R6: Entry format: bit 31 present, bit 30 writable, bit 29 referenced, bit 28 modified, bits 17:0 page number. At levels 1 and 2, the page number of a present entry becomes the next table's page number.
- R7: The first entry with bit 31 clear ends the walk with `resFault`=1 and `resLevel` equal to that level, encoded 1, 2 or 3. No further read is issued.
- R8: A walk whose three entries are present ends with `resFault`=0. It returns `resPpn` and the three flags from the level-3 entry, `resPa` = {page number, VA offset} and `resLevel`=3. `resPid` echoes the request PID on every result.
- R9: A request is accepted only when `reqReady` is 1. `reqReady` is 0 from the cycle after acceptance until the walker is idle again, and `reqValid` during that time is ignored.
- R10: `resValid` is a one-cycle pulse, appearing the cycle after the deciding response. `reqReady` returns to 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Miss request present |
| reqReady | output | 1 | Walker idle, can accept a request |
| reqVa | input | 42 | Virtual address to translate |
| reqPid | input | 8 | Process ID of the request |
| ptBasePpn | input | 18 | Page number of the root table |
| memReqValid | output | 1 | Read request strobe |
| memReqAddr | output | 30 | Byte address of the entry to read |
| memRespValid | input | 1 | Read data valid |
| memRespData | input | 32 | Entry read from memory |
| resValid | output | 1 | Result pulse |
| resFault | output | 1 | Walk ended on a non-present entry |
| resLevel | output | 2 | Level of the last entry examined (1 to 3) |
| resPid | output | 8 | PID of the finished walk |
| resPpn | output | 18 | Translated physical page number |
| resPa | output | 30 | Translated physical byte address |
| resWritable | output | 1 | Writable flag of the final entry |
| resReferenced | output | 1 | Referenced flag of the final entry |
| resModified | output | 1 | Modified flag of the final entry |

## Verification
The assertions check on every cycle that read strobes and result strobes are single-cycle pulses, and that the walker goes idle after each result. They also check that a fault never reports level 0, and that a level step aims the next read at the page number just returned. The bench scenarios show what the assertions cannot. These are the exact read addresses derived from the index fields, and the tolerance of arbitrary response latency. They also include the rejection of stray responses, both in the request cycle and while idle. Finally, the bench checks that the base input and requests arriving during a walk are ignored, and that the returned page, flags and fault level are correct.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W   = 42;
  localparam int IDX_W  = 10;
  localparam int OFF_W  = 12;
  localparam int LEVELS = 3;
  localparam int PPN_W  = 18;
  localparam int PTE_W  = 32;
  localparam int PID_W  = 8;
  localparam int PA_W   = PPN_W + OFF_W;
  localparam int LVL_W  = 2;

  localparam int PRESENT_BIT = 31;
  localparam int WRITE_BIT   = 30;
  localparam int REF_BIT     = 29;
  localparam int MOD_BIT     = 28;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1, ST_L2, ST_L3, ST_DONE, ST_FAULT
  } walkState_t;

  typedef struct packed {
    logic             loadReq;
    logic             stepBase;
    logic             capture;
    logic [LVL_W-1:0] level;
  } walkStrb_t;
endpackage

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  walkStrb_t        strb,
  input  logic [VA_W-1:0]  reqVa,
  input  logic [PID_W-1:0] reqPid,
  input  logic [PPN_W-1:0] ptBasePpn,
  input  logic [PTE_W-1:0] memRespData,
  output logic             pteValid,
  output logic [PA_W-1:0]  memReqAddr,
  output logic [LVL_W-1:0] resLevel,
  output logic [PID_W-1:0] resPid,
  output logic [PPN_W-1:0] resPpn,
  output logic [PA_W-1:0]  resPa,
  output logic             resWritable,
  output logic             resReferenced,
  output logic             resModified
);
  logic [VA_W-1:0]  vaReg;
  logic [PID_W-1:0] pidReg;
  logic [PPN_W-1:0] tableBase;
  logic [PTE_W-1:0] entryReg;
  logic [LVL_W-1:0] lvlReg;

  logic [IDX_W-1:0] idxArr [LEVELS];
  logic [IDX_W-1:0] idxSel;

  genvar g;
  generate
    for (g = 0; g < LEVELS; g++) begin : gIdx
      assign idxArr[g] = vaReg[VA_W-1-g*IDX_W -: IDX_W];
    end
  endgenerate

  always_comb begin
    idxSel = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (strb.level == LVL_W'(i + 1)) idxSel = idxArr[i];
    end
  end

  assign memReqAddr = {tableBase, {OFF_W{1'b0}}}
                    + {{(PA_W-IDX_W-2){1'b0}}, idxSel, 2'b00};
  assign pteValid   = memRespData[PRESENT_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaReg     <= '0;
      pidReg    <= '0;
      tableBase <= '0;
      entryReg  <= '0;
      lvlReg    <= '0;
    end else begin
      if (strb.loadReq) begin
        vaReg     <= reqVa;
        pidReg    <= reqPid;
        tableBase <= ptBasePpn;
      end
      if (strb.stepBase) tableBase <= memRespData[PPN_W-1:0];
      if (strb.capture) begin
        entryReg <= memRespData;
        lvlReg   <= strb.level;
      end
    end
  end

  assign resLevel      = lvlReg;
  assign resPid        = pidReg;
  assign resPpn        = entryReg[PPN_W-1:0];
  assign resPa         = {entryReg[PPN_W-1:0], vaReg[OFF_W-1:0]};
  assign resWritable   = entryReg[WRITE_BIT];
  assign resReferenced = entryReg[REF_BIT];
  assign resModified   = entryReg[MOD_BIT];

  // R6: a level step points the next read at the page number just returned
  assert_next_table_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepBase |=> memReqAddr[PA_W-1:OFF_W] == $past(memRespData[PPN_W-1:0]));
endmodule

// File: rtl/ptw_control.sv
module ptw_control
  import ptw_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      memRespValid,
  input  logic      pteValid,
  output logic      reqReady,
  output logic      memReqValid,
  output logic      resValid,
  output logic      resFault,
  output walkStrb_t strb
);
  walkState_t state, stateNext;
  logic       waiting, waitingNext;
  logic       inWalk, respTake;

  assign inWalk      = (state == ST_L1) || (state == ST_L2) || (state == ST_L3);
  assign memReqValid = inWalk && !waiting;
  assign respTake    = inWalk && waiting && memRespValid;
  assign reqReady    = (state == ST_IDLE);
  assign resValid    = (state == ST_DONE) || (state == ST_FAULT);
  assign resFault    = (state == ST_FAULT);

  always_comb begin
    strb = '0;
    unique case (state)
      ST_L1:   strb.level = 2'd1;
      ST_L2:   strb.level = 2'd2;
      ST_L3:   strb.level = 2'd3;
      default: strb.level = 2'd0;
    endcase
    strb.loadReq  = (state == ST_IDLE) && reqValid;
    strb.stepBase = respTake && pteValid && (state != ST_L3);
    strb.capture  = respTake && (!pteValid || state == ST_L3);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (reqValid) stateNext = ST_L1;
      ST_L1:   if (respTake) stateNext = pteValid ? ST_L2 : ST_FAULT;
      ST_L2:   if (respTake) stateNext = pteValid ? ST_L3 : ST_FAULT;
      ST_L3:   if (respTake) stateNext = pteValid ? ST_DONE : ST_FAULT;
      default: stateNext = ST_IDLE;
    endcase
    waitingNext = waiting;
    if (respTake) waitingNext = 1'b0;
    else if (memReqValid) waitingNext = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waiting <= 1'b0;
    end else begin
      state   <= stateNext;
      waiting <= waitingNext;
    end
  end

  // R4: one read strobe per level, never two cycles in a row
  assert_req_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);
  // R10: result is a single-cycle pulse
  assert_res_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);
  // R10: walker is ready again right after a result
  assert_idle_after_res_R10: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> reqReady);
  // R9: an accepted request makes the walker busy
  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid) |=> !reqReady);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [VA_W-1:0]  reqVa,
  input  logic [PID_W-1:0] reqPid,
  input  logic [PPN_W-1:0] ptBasePpn,
  output logic             memReqValid,
  output logic [PA_W-1:0]  memReqAddr,
  input  logic             memRespValid,
  input  logic [PTE_W-1:0] memRespData,
  output logic             resValid,
  output logic             resFault,
  output logic [LVL_W-1:0] resLevel,
  output logic [PID_W-1:0] resPid,
  output logic [PPN_W-1:0] resPpn,
  output logic [PA_W-1:0]  resPa,
  output logic             resWritable,
  output logic             resReferenced,
  output logic             resModified
);
  walkStrb_t strb;
  logic      pteValid;

  ptw_control u_ctrl (
    .clk, .rstN, .reqValid, .memRespValid, .pteValid,
    .reqReady, .memReqValid, .resValid, .resFault, .strb
  );

  ptw_datapath u_dp (
    .clk, .rstN, .strb, .reqVa, .reqPid, .ptBasePpn, .memRespData,
    .pteValid, .memReqAddr, .resLevel, .resPid, .resPpn, .resPa,
    .resWritable, .resReferenced, .resModified
  );

  // R7: a fault always names a real level
  assert_fault_level_R7: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resFault) |-> (resLevel != 2'd0));
  // R8: a successful walk reports the last level
  assert_done_level_R8: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resFault) |-> (resLevel == 2'd3));
endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [41:0] reqVa = '0;
  logic [7:0]  reqPid = '0;
  logic [17:0] ptBasePpn = '0;
  logic        memReqValid;
  logic [29:0] memReqAddr;
  logic        memRespValid = 1'b0;
  logic [31:0] memRespData = '0;
  logic        resValid, resFault;
  logic [1:0]  resLevel;
  logic [7:0]  resPid;
  logic [17:0] resPpn;
  logic [29:0] resPa;
  logic        resWritable, resReferenced, resModified;

  int checkCount = 0;
  int failCount  = 0;

  always #2.5 clk = ~clk;

  pt_walker u_pt_walker (
    .clk, .rstN, .reqValid, .reqReady, .reqVa, .reqPid, .ptBasePpn,
    .memReqValid, .memReqAddr, .memRespValid, .memRespData,
    .resValid, .resFault, .resLevel, .resPid, .resPpn, .resPa,
    .resWritable, .resReferenced, .resModified
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] idxOf(input logic [41:0] va, input int lvl);
    return va[41 - 10*lvl -: 10];
  endfunction

  function automatic logic [29:0] expAddr(input logic [17:0] base, input logic [9:0] idx);
    return {base, 12'h000} + 30'(idx) * 30'd4;
  endfunction

  function automatic logic [31:0] mkEntry(input bit present);
    logic [31:0] e;
    e = $urandom;
    e[31] = present;
    return e;
  endfunction

  task automatic doWalk(input logic [41:0] va, input logic [7:0] pid,
                        input logic [17:0] base, input logic [31:0] e1,
                        input logic [31:0] e2, input logic [31:0] e3,
                        input int dly, input bit strayInReqCycle);
    logic [31:0] ents [3];
    logic [17:0] curBase;
    int faultLvl;
    ents = '{e1, e2, e3};
    curBase = base;
    faultLvl = 0;
    @(negedge clk);
    reqValid = 1'b1; reqVa = va; reqPid = pid; ptBasePpn = base;
    @(negedge clk);
    ptBasePpn = 18'($urandom);
    reqVa = ~va; reqPid = ~pid;
    check(reqReady == 1'b0, "R9 busy after accept", 64'(reqReady), 64'd0);
    for (int lvl = 0; lvl < 3; lvl++) begin
      check(memReqValid == 1'b1, "R4 read strobe at level start", 64'(memReqValid), 64'd1);
      check(memReqAddr == expAddr(curBase, idxOf(va, lvl)), "R3 entry address",
            64'(memReqAddr), 64'(expAddr(curBase, idxOf(va, lvl))));
      if (strayInReqCycle && lvl == 0) begin
        memRespValid = 1'b1; memRespData = 32'h0000_0000;
      end
      @(negedge clk);
      memRespValid = 1'b0;
      for (int d = 0; d < dly; d++) begin
        check(memReqValid == 1'b0, "R4 no read while waiting", 64'(memReqValid), 64'd0);
        check(reqReady == 1'b0, "R9 stays busy", 64'(reqReady), 64'd0);
        @(negedge clk);
      end
      memRespValid = 1'b1; memRespData = ents[lvl];
      @(negedge clk);
      memRespValid = 1'b0;
      if (!ents[lvl][31]) begin
        faultLvl = lvl + 1;
        break;
      end
      curBase = ents[lvl][17:0];
    end
    reqValid = 1'b0;
    check(resValid == 1'b1, "R10 result one cycle after response", 64'(resValid), 64'd1);
    check(memReqValid == 1'b0, "R7 no read after end of walk", 64'(memReqValid), 64'd0);
    check(resPid == pid, "R8 PID echoed", 64'(resPid), 64'(pid));
    if (faultLvl != 0) begin
      check(resFault == 1'b1, "R7 fault flagged", 64'(resFault), 64'd1);
      check(resLevel == 2'(faultLvl), "R7 fault level", 64'(resLevel), 64'(faultLvl));
    end else begin
      check(resFault == 1'b0, "R8 no fault", 64'(resFault), 64'd0);
      check(resLevel == 2'd3, "R8 level three", 64'(resLevel), 64'd3);
      check(resPpn == e3[17:0], "R8 page number", 64'(resPpn), 64'(e3[17:0]));
      check(resPa == {e3[17:0], va[11:0]}, "R8 physical address",
            64'(resPa), 64'({e3[17:0], va[11:0]}));
      check({resWritable, resReferenced, resModified} == e3[30:28], "R6 flag bits",
            64'({resWritable, resReferenced, resModified}), 64'(e3[30:28]));
    end
    @(negedge clk);
    check(resValid == 1'b0, "R10 result pulse ends", 64'(resValid), 64'd0);
    check(reqReady == 1'b1, "R10 ready again", 64'(reqReady), 64'd1);
    check(memReqValid == 1'b0, "R9 busy request ignored", 64'(memReqValid), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCount++;
    checkCount++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(reqReady == 1'b1, "R1 ready in reset", 64'(reqReady), 64'd1);
    check(memReqValid == 1'b0, "R1 no read in reset", 64'(memReqValid), 64'd0);
    check(resValid == 1'b0, "R1 no result in reset", 64'(resValid), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R5: stray responses while idle are ignored
    memRespValid = 1'b1; memRespData = 32'h8000_1234;
    repeat (2) @(negedge clk);
    check(resValid == 1'b0, "R5 idle response ignored", 64'(resValid), 64'd0);
    check(memReqValid == 1'b0, "R5 idle response starts nothing", 64'(memReqValid), 64'd0);
    check(reqReady == 1'b1, "R5 still idle", 64'(reqReady), 64'd1);
    memRespValid = 1'b0;

    // R2 R3: all-ones indices, full walk, no latency
    doWalk({10'h3FF, 10'h3FF, 10'h3FF, 12'hFFF}, 8'hA5, 18'h3FFFF,
           32'h8000_0001, 32'h8002_0002, 32'hF003_FFFF, 0, 1'b0);
    // R5: response in the request cycle ignored, long latency
    doWalk({10'h001, 10'h200, 10'h155, 12'h123}, 8'h11, 18'h00010,
           32'h8000_0100, 32'h8000_0200, 32'hA000_0300, 7, 1'b1);
    // R7: fault at each level
    doWalk(42'h2_1234_5678, 8'h01, 18'h00777, 32'h7FFF_FFFF, 32'h8000_0001,
           32'h8000_0002, 1, 1'b0);
    doWalk(42'h1_0F0F_0F0F, 8'h02, 18'h01234, 32'h8000_4444, 32'h0000_0000,
           32'h8000_0002, 2, 1'b0);
    doWalk(42'h3_FFFF_0000, 8'h03, 18'h00001, 32'h8000_0005, 32'h8000_0006,
           32'h4FFF_FFFF, 0, 1'b0);

    // Random walks: R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int n = 0; n < 60; n++) begin
      int fl;
      logic [41:0] va;
      va = {10'($urandom), $urandom};
      fl = $urandom_range(0, 5);
      doWalk(va, 8'($urandom), 18'($urandom),
             mkEntry(fl != 1), mkEntry(fl != 2), mkEntry(fl != 3),
             $urandom_range(0, 4), 1'($urandom));
    end

    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end
endmodule